// File: doc/BRIEF.md
# Bus Transceiver Mode and Wake Sequencer

This block is the digital control core of a low-speed single-wire automotive bus transceiver. From a supply-good flag, a host enable line, a filtered bus-dominant comparator output and an active-low local wake switch, it steps through four modes: off, standby, active and sleep. From the mode it drives the regulator enable, the communication enable and the bus termination select.

Every time qualification (enable confirm, enable release, bus wake, switch wake) counts pulses of a one-microsecond tick. The counter limits are parameters, so the same block serves any clock rate. When a wake request is qualified in sleep, the block returns to standby. It latches a wake flag, which forces the receive line low, and it latches the wake source. A switch wake turns on a strong pull-down on the transmit pin. A bus wake leaves only the weak one. Both flags drop once the host raises enable.

Top module: `bxc_ctrl`

## Requirements
- R1: In off mode, a high supply_ok_i moves the block to standby on the next clock edge.
- R2: A low supply_ok_i returns the block to off mode from any mode on the next clock edge. In off mode all outputs are low and both wake flags are cleared.
- R3: In standby, enable_i held high for NORM_TICKS tick pulses moves the block to active one edge after the last of those pulses.
- R4: In active, enable_i held low for SLEEP_TICKS tick pulses moves the block to sleep.
- R5: mode_o encodes off=0, standby=1, active=2, sleep=3. reg_en_o and term_on_o are high in standby and active only. comm_en_o is high in active only.
- R6: In sleep, bus_dom_i held high for BUS_TICKS tick pulses moves the block to standby. It sets rx_force_low_o and leaves tx_strong_pd_o low.
- R7: In sleep, wake_sw_n_i held low for WAKE_TICKS tick pulses moves the block to standby. It sets both rx_force_low_o and tx_strong_pd_o.
- R8: The wake flags stay set while enable_i is low. Any clock edge with enable_i high clears both, and a clear wins over a new set on the same edge.
- R9: Each qualifying counter restarts from zero whenever its input goes back to the inactive level before the count completes.
- R10: The counters advance only on clock edges where us_tick_i is high.
- R11: A wake input that is already active when sleep begins does not count. It must first be seen inactive while in sleep, which gives the falling edge the wake needs.
- R12: If the bus and switch wake counts complete on the same edge, the switch is recorded as the source (tx_strong_pd_o high).

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| enable_i | input | 1 | Host mode request; reads low when unconnected |
| bus_dom_i | input | 1 | Bus comparator output, high when dominant |
| wake_sw_n_i | input | 1 | Local wake switch, active low |
| mode_o | output | 2 | Current mode (see R5) |
| reg_en_o | output | 1 | External regulator enable |
| comm_en_o | output | 1 | Transmit and receive paths enabled |
| term_on_o | output | 1 | Full termination on; low selects weak pull-up |
| rx_force_low_o | output | 1 | Wake flag: hold receive line low |
| tx_strong_pd_o | output | 1 | Wake source: strong pull-down on transmit pin |

## Verification
The mode sequence is driven by a walk through all four modes, in which each qualification is held a few ticks short of its limit and then carried past it. This separates the correct limit from early or late transitions. A dominant pulse cut short and then repeated shows that the counter restarts rather than accumulates. Gated ticks show that counting follows the tick and not the clock. A bus held dominant across sleep entry, and two wake inputs timed to complete on the same edge, tell apart edge-qualified wakes from level-qualified ones and switch priority from bus priority.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
   typedef enum logic [1:0] {
      MODE_OFF     = 2'd0,
      MODE_STANDBY = 2'd1,
      MODE_ACTIVE  = 2'd2,
      MODE_SLEEP   = 2'd3
   } mode_e;
endpackage

// File: rtl/bxc_filter.sv
// Tick-counted qualifier: hit_o rises once act_i has stayed high for LIMIT
// ticks while run_i is high. NEED_EDGE requires act_i to be seen low first.
module bxc_filter #(
   parameter int unsigned LIMIT     = 10,
   parameter bit          NEED_EDGE = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   input  logic act_i,
   output logic hit_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   initial begin
      if (LIMIT == 0) $fatal(1, "bxc_filter: LIMIT must be at least 1");
   end

   logic          armed;
   logic [CW-1:0] cnt_q;

   generate
      if (NEED_EDGE) begin : g_edge
         logic armed_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     armed_q <= 1'b0;
            else if (!run_i) armed_q <= 1'b0;
            else if (!act_i) armed_q <= 1'b1;
         end
         assign armed = armed_q;
      end else begin : g_level
         assign armed = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         hit_o <= 1'b0;
      end else if (!run_i || !act_i || !armed) begin
         cnt_q <= '0;
         hit_o <= 1'b0;
      end else if (tick_i && !hit_o) begin
         if (cnt_q == CW'(LIMIT - 1)) hit_o <= 1'b1;
         else                         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bxc_mode_seq.sv
module bxc_mode_seq
   import bxc_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  supply_ok_i,
   input  logic  norm_hit_i,
   input  logic  sleep_hit_i,
   input  logic  wake_hit_i,
   output mode_e mode_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mode_o <= MODE_OFF;
      else if (!supply_ok_i) mode_o <= MODE_OFF;
      else begin
         unique case (mode_o)
            MODE_OFF:     mode_o <= MODE_STANDBY;
            MODE_STANDBY: if (norm_hit_i)  mode_o <= MODE_ACTIVE;
            MODE_ACTIVE:  if (sleep_hit_i) mode_o <= MODE_SLEEP;
            MODE_SLEEP:   if (wake_hit_i)  mode_o <= MODE_STANDBY;
            default:      mode_o <= MODE_OFF;
         endcase
      end
   end
endmodule

// File: rtl/bxc_wake_flag.sv
module bxc_wake_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic supply_ok_i,
   input  logic enable_i,
   input  logic set_i,
   input  logic local_i,
   output logic req_o,
   output logic local_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_o   <= 1'b0;
         local_o <= 1'b0;
      end else if (!supply_ok_i || enable_i) begin
         req_o   <= 1'b0;
         local_o <= 1'b0;
      end else if (set_i) begin
         req_o   <= 1'b1;
         local_o <= local_i;
      end
   end
endmodule

// File: rtl/bxc_ctrl.sv
module bxc_ctrl
   import bxc_pkg::*;
#(
   parameter int unsigned NORM_TICKS   = 10,
   parameter int unsigned SLEEP_TICKS  = 10,
   parameter int unsigned BUS_TICKS    = 90,
   parameter int unsigned WAKE_TICKS   = 130,
   parameter bit          REQUIRE_EDGE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       us_tick_i,
   input  logic       supply_ok_i,
   input  logic       enable_i,
   input  logic       bus_dom_i,
   input  logic       wake_sw_n_i,
   output logic [1:0] mode_o,
   output logic       reg_en_o,
   output logic       comm_en_o,
   output logic       term_on_o,
   output logic       rx_force_low_o,
   output logic       tx_strong_pd_o
);
   mode_e mode;
   logic  norm_hit, sleep_hit, bus_hit, loc_hit;
   logic  flag_req, flag_loc;

   bxc_filter #(.LIMIT(NORM_TICKS), .NEED_EDGE(1'b0)) u_norm (
      .clk_i, .rst_ni, .run_i(mode == MODE_STANDBY), .tick_i(us_tick_i),
      .act_i(enable_i), .hit_o(norm_hit));

   bxc_filter #(.LIMIT(SLEEP_TICKS), .NEED_EDGE(1'b0)) u_sleep (
      .clk_i, .rst_ni, .run_i(mode == MODE_ACTIVE), .tick_i(us_tick_i),
      .act_i(!enable_i), .hit_o(sleep_hit));

   bxc_filter #(.LIMIT(BUS_TICKS), .NEED_EDGE(REQUIRE_EDGE)) u_bus (
      .clk_i, .rst_ni, .run_i(mode == MODE_SLEEP), .tick_i(us_tick_i),
      .act_i(bus_dom_i), .hit_o(bus_hit));

   bxc_filter #(.LIMIT(WAKE_TICKS), .NEED_EDGE(REQUIRE_EDGE)) u_loc (
      .clk_i, .rst_ni, .run_i(mode == MODE_SLEEP), .tick_i(us_tick_i),
      .act_i(!wake_sw_n_i), .hit_o(loc_hit));

   bxc_mode_seq u_seq (
      .clk_i, .rst_ni, .supply_ok_i,
      .norm_hit_i(norm_hit), .sleep_hit_i(sleep_hit),
      .wake_hit_i(bus_hit | loc_hit), .mode_o(mode));

   // switch source wins when both qualify together (R12)
   bxc_wake_flag u_flag (
      .clk_i, .rst_ni, .supply_ok_i, .enable_i,
      .set_i(bus_hit | loc_hit), .local_i(loc_hit),
      .req_o(flag_req), .local_o(flag_loc));

   always_comb begin
      reg_en_o  = (mode == MODE_STANDBY) || (mode == MODE_ACTIVE);
      term_on_o = reg_en_o;
      comm_en_o = (mode == MODE_ACTIVE);
   end

   assign mode_o         = mode;
   assign rx_force_low_o = flag_req;
   assign tx_strong_pd_o = flag_req & flag_loc;
endmodule

// File: rtl/bxc_chk.sv
module bxc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       supply_ok_i,
   input logic       enable_i,
   input logic [1:0] mode_o,
   input logic       reg_en_o,
   input logic       comm_en_o,
   input logic       term_on_o,
   input logic       rx_force_low_o,
   input logic       tx_strong_pd_o
);
   assert_power_up_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd0 && supply_ok_i) |=> (mode_o == 2'd1));

   assert_supply_loss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !supply_ok_i |=> (mode_o == 2'd0 && !reg_en_o && !rx_force_low_o));

   assert_sleep_outputs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd3) |-> (!reg_en_o && !comm_en_o && !term_on_o));

   assert_comm_needs_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comm_en_o |-> reg_en_o);

   assert_wake_from_sleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_force_low_o) |-> (mode_o == 2'd1 && $past(mode_o) == 2'd3));

   assert_source_implies_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_strong_pd_o |-> rx_force_low_o);

   assert_enable_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enable_i |=> !rx_force_low_o);
endmodule

bind bxc_ctrl bxc_chk u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
   .enable_i(enable_i), .mode_o(mode_o), .reg_en_o(reg_en_o),
   .comm_en_o(comm_en_o), .term_on_o(term_on_o),
   .rx_force_low_o(rx_force_low_o), .tx_strong_pd_o(tx_strong_pd_o));

// File: tb/tb_bxc_ctrl.sv
module tb_bxc_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       sup = 1'b0, en = 1'b0, bus = 1'b0, wkn = 1'b1;
   logic [1:0] mode;
   logic       reg_en, comm_en, term_on, rx_low, tx_pd;
   int         checks = 0;
   int         errors = 0;

   always #5 clk = ~clk;

   bxc_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .supply_ok_i(sup),
      .enable_i(en), .bus_dom_i(bus), .wake_sw_n_i(wkn), .mode_o(mode),
      .reg_en_o(reg_en), .comm_en_o(comm_en), .term_on_o(term_on),
      .rx_force_low_o(rx_low), .tx_strong_pd_o(tx_pd));

   typedef struct packed {
      logic       s, e, b, w;
      logic [7:0] cyc;
      logic [1:0] md;
      logic [2:0] oe;   // {reg_en, comm_en, term_on}
      logic       rx, tx;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,1'b1,8'd3,  2'd0,3'b000,1'b0,1'b0,4'd2},  // R2 off
      '{1'b1,1'b0,1'b0,1'b1,8'd3,  2'd1,3'b101,1'b0,1'b0,4'd1},  // R1 up
      '{1'b1,1'b1,1'b0,1'b1,8'd8,  2'd1,3'b101,1'b0,1'b0,4'd3},  // R3 short
      '{1'b1,1'b1,1'b0,1'b1,8'd5,  2'd2,3'b111,1'b0,1'b0,4'd3},  // R3 done
      '{1'b1,1'b0,1'b0,1'b1,8'd8,  2'd2,3'b111,1'b0,1'b0,4'd4},  // R4 short
      '{1'b1,1'b0,1'b0,1'b1,8'd5,  2'd3,3'b000,1'b0,1'b0,4'd4},  // R4 done
      '{1'b1,1'b0,1'b1,1'b1,8'd60, 2'd3,3'b000,1'b0,1'b0,4'd9},  // R9 part
      '{1'b1,1'b0,1'b0,1'b1,8'd2,  2'd3,3'b000,1'b0,1'b0,4'd9},  // R9 drop
      '{1'b1,1'b0,1'b1,1'b1,8'd60, 2'd3,3'b000,1'b0,1'b0,4'd9},  // R9 restart
      '{1'b1,1'b0,1'b1,1'b1,8'd40, 2'd1,3'b101,1'b1,1'b0,4'd6},  // R6 bus wake
      '{1'b1,1'b1,1'b0,1'b1,8'd3,  2'd1,3'b101,1'b0,1'b0,4'd8},  // R8 clear
      '{1'b1,1'b1,1'b0,1'b1,8'd12, 2'd2,3'b111,1'b0,1'b0,4'd3},  // R3
      '{1'b1,1'b0,1'b0,1'b1,8'd14, 2'd3,3'b000,1'b0,1'b0,4'd4},  // R4
      '{1'b1,1'b0,1'b0,1'b0,8'd125,2'd3,3'b000,1'b0,1'b0,4'd7},  // R7 short
      '{1'b1,1'b0,1'b0,1'b0,8'd10, 2'd1,3'b101,1'b1,1'b1,4'd7},  // R7 done
      '{1'b1,1'b0,1'b0,1'b1,8'd20, 2'd1,3'b101,1'b1,1'b1,4'd8},  // R8 hold
      '{1'b1,1'b1,1'b0,1'b1,8'd1,  2'd1,3'b101,1'b0,1'b0,4'd8},  // R8 one edge
      '{1'b1,1'b1,1'b0,1'b1,8'd12, 2'd2,3'b111,1'b0,1'b0,4'd5},  // R5 active
      '{1'b0,1'b1,1'b0,1'b1,8'd1,  2'd0,3'b000,1'b0,1'b0,4'd2},  // R2 loss
      '{1'b1,1'b1,1'b0,1'b1,8'd2,  2'd1,3'b101,1'b0,1'b0,4'd1}   // R1 again
   };

   function automatic logic [6:0] obs();
      return {mode, reg_en, comm_en, term_on, rx_low, tx_pd};
   endfunction

   task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got mode/oe/rx/tx=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // reset state, R5 encoding of off mode
      run(3);
      check("R5 reset", obs(), 7'b00_000_0_0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         sup = VEC[i].s; en = VEC[i].e; bus = VEC[i].b; wkn = VEC[i].w;
         run(int'(VEC[i].cyc));
         check($sformatf("R%0d vec%0d", VEC[i].req, i), obs(),
               {VEC[i].md, VEC[i].oe, VEC[i].rx, VEC[i].tx});
      end

      // R10: no count without tick (standby, enable high, one tick counted)
      tick = 1'b0;
      run(30);
      check("R10 gated", obs(), 7'b01_101_0_0);
      tick = 1'b1;
      run(12);
      check("R10 resumed", obs(), 7'b10_111_0_0);

      // R11: bus already dominant when sleep begins
      en = 1'b0; bus = 1'b1;
      run(14);
      check("R11 sleep entry", obs(), 7'b11_000_0_0);
      run(200);
      check("R11 no edge", obs(), 7'b11_000_0_0);
      bus = 1'b0;
      run(2);
      bus = 1'b1;
      run(100);
      check("R11 after edge", obs(), 7'b01_101_1_0);

      // R12: both wake counts complete on the same edge
      bus = 1'b0; en = 1'b1;
      run(15);
      check("R12 setup", obs(), 7'b10_111_0_0);
      en = 1'b0;
      run(14);
      wkn = 1'b0;
      run(40);
      bus = 1'b1;
      run(95);
      check("R12 tie", obs(), 7'b01_101_1_1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule